// File: doc/BRIEF.md
# Relocatable Peripheral Window Address Decoder

This block decides where each processor access goes. It holds one base register. That register places a 64 KB window for the on-chip peripherals anywhere in the 32-bit address space. The register also carries a valid flag and four mask bits, one for each combination of privilege level and code/data space. A set mask bit removes that kind of access from the window.

For every access, the block combines the register with the access attributes and with hit flags from on-chip memory and the chip-select logic. It then raises exactly one of four target selects. A fixed priority settles overlaps. On-chip memory wins first, then the peripheral window, then chip-select, and the external bus takes everything else.

The decode is purely combinational on the access inputs. The register changes only on a clock edge, and only when a supervisor-mode write is presented.

Top module: `pwin_decoder`

## Requirements
- R1: After reset, the readback is 0x0000_0000 and no access is sent to the peripheral window.
- R2: A write with `reg_wr_en`=1 and `acc_super`=1 is stored at the next rising clock edge. The readback then shows bits 31–16 (window base), bits 4–1 (masks) and bit 0 (valid) as written.
- R3: Readback bits 15–5 are always zero, whatever value was written to them.
- R4: A write presented with `acc_super`=0 leaves the register, and therefore the readback, unchanged.
- R5: With valid=1, an access whose address bits 31–16 equal the base field, and whose type is not masked, selects the peripheral window (`tgt_sel`=4'b0010).
- R6: With valid=0, the peripheral window is never selected.
- R7: Mask bit 4 excludes supervisor code, bit 3 supervisor data, bit 2 user code and bit 1 user data. A masked access inside the window, with no other hit, goes to the external bus (`tgt_sel`=4'b1000).
- R8: When `mem_hit`=1, the on-chip memory target (`tgt_sel`=4'b0001) is selected, and neither the peripheral window nor the external bus is selected.
- R9: When the window hits and `cs_hit`=1 with no memory hit, the peripheral window wins over chip-select.
- R10: With no memory hit and no window hit, `cs_hit`=1 selects chip-select (`tgt_sel`=4'b0100).
- R11: With no hit of any kind, the external bus is selected (`tgt_sel`=4'b1000).
- R12: Exactly one bit of `tgt_sel` is set at all times out of reset.
- R13: Writing 0x1000_0001 places the window at 0x1000_0000, with all access types allowed and valid set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_addr | input | 32 | Access address |
| acc_super | input | 1 | 1 = supervisor access, 0 = user access |
| acc_code | input | 1 | 1 = code space, 0 = data space |
| mem_hit | input | 1 | On-chip memory (SRAM, ROM or cache) claims the access |
| cs_hit | input | 1 | A chip-select region claims the access |
| reg_wr_en | input | 1 | Base register write strobe |
| reg_wr_data | input | 32 | Base register write value |
| reg_rd_data | output | 32 | Base register readback |
| tgt_sel | output | 4 | One-hot target: bit0 memory, bit1 peripheral window, bit2 chip-select, bit3 external bus |

## Verification
The decode is tried with all four access types against each single mask bit. This shows that every mask bit guards exactly one privilege/space pair and not a neighbour. Addresses just inside and just outside the window, including a base change made between accesses, separate the base compare from the valid gate. All eight combinations of memory hit, window hit and chip-select hit are applied, so each overlap shows which level of the priority chain wins. Writes with the reserved bits set, and writes made from user mode, show that readback masking and write gating are each working.

// File: rtl/pwin_pkg.sv
package pwin_pkg;

    // Target indices; lower index wins when several claim an access.
    typedef enum logic [1:0] {
        TGT_MEM    = 2'd0,
        TGT_PERIPH = 2'd1,
        TGT_CS     = 2'd2,
        TGT_EXT    = 2'd3
    } tgt_e;

    localparam int TGT_N   = 4;
    localparam int MASK_N  = 4;
    localparam int MASK_LO = 1;  // masks sit in bits MASK_LO+MASK_N-1 .. MASK_LO
    localparam int VALID_B = 0;

endpackage

// File: rtl/pwin_basereg.sv
module pwin_basereg
    import pwin_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int WIN_BITS = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic                         wr_super,
    input  logic [ADDR_W-1:0]            wr_data,
    output logic [ADDR_W-1:0]            rd_data,
    output logic [ADDR_W-WIN_BITS-1:0]   base_o,
    output logic [MASK_N-1:0]            mask_o,
    output logic                         valid_o
);
    localparam int BASE_W = ADDR_W - WIN_BITS;
    localparam int RSV_LO = MASK_LO + MASK_N;
    localparam int RSV_W  = WIN_BITS - RSV_LO;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [MASK_N-1:0] mask;
        logic              valid;
    } breg_t;

    breg_t reg_d, reg_q;
    logic  rsv_unused;

    assign rsv_unused = ^wr_data[WIN_BITS-1:RSV_LO];

    always_comb begin
        reg_d = reg_q;
        if (wr_en && wr_super) begin
            reg_d.base  = wr_data[ADDR_W-1:WIN_BITS];
            reg_d.mask  = wr_data[RSV_LO-1:MASK_LO];
            reg_d.valid = wr_data[VALID_B];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end

    assign rd_data = {reg_q.base, {RSV_W{1'b0}}, reg_q.mask, reg_q.valid};
    assign base_o  = reg_q.base;
    assign mask_o  = reg_q.mask;
    assign valid_o = reg_q.valid;

    // R2: supervisor write lands on the next edge
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_super) |=>
            (rd_data[ADDR_W-1:WIN_BITS] == $past(wr_data[ADDR_W-1:WIN_BITS]) &&
             rd_data[RSV_LO-1:0] == $past(wr_data[RSV_LO-1:0])));

    // R4: user-mode write has no effect
    a_r4_user_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_super) |=> $stable(rd_data));

    // R3: reserved field reads as zero
    a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[WIN_BITS-1:RSV_LO] == '0);

endmodule

// File: rtl/pwin_space_match.sv
module pwin_space_match
    import pwin_pkg::*;
#(
    parameter int BASE_W = 16
) (
    input  logic [BASE_W-1:0] addr_hi,
    input  logic              acc_super,
    input  logic              acc_code,
    input  logic [BASE_W-1:0] base,
    input  logic [MASK_N-1:0] mask,
    input  logic              valid,
    output logic              in_window,
    output logic              win_hit
);
    logic [1:0] space_idx;
    logic       space_blocked;

    // Index 3 supervisor code, 2 supervisor data, 1 user code, 0 user data.
    always_comb begin
        space_idx     = {acc_super, acc_code};
        space_blocked = mask[space_idx];
        in_window     = valid && (addr_hi == base);
        win_hit       = in_window && !space_blocked;
    end

endmodule

// File: rtl/pwin_priority.sv
module pwin_priority #(
    parameter int NREQ = 4
) (
    input  logic [NREQ-1:0] req,
    output logic [NREQ-1:0] grant
);
    logic taken;

    always_comb begin
        grant = '0;
        taken = 1'b0;
        for (int i = 0; i < NREQ; i++) begin
            if (req[i] && !taken) begin
                grant[i] = 1'b1;
                taken    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/pwin_decoder.sv
module pwin_decoder
    import pwin_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int WIN_BITS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_super,
    input  logic              acc_code,
    input  logic              mem_hit,
    input  logic              cs_hit,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_wr_data,
    output logic [ADDR_W-1:0] reg_rd_data,
    output logic [TGT_N-1:0]  tgt_sel
);
    localparam int BASE_W = ADDR_W - WIN_BITS;

    logic [BASE_W-1:0] base_q;
    logic [MASK_N-1:0] mask_q;
    logic              valid_q;
    logic              in_window;
    logic              win_hit;
    logic [TGT_N-1:0]  req_vec;
    logic              addr_unused;

    assign addr_unused = ^acc_addr[WIN_BITS-1:0];

    pwin_basereg #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_basereg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .wr_super (acc_super),
        .wr_data  (reg_wr_data),
        .rd_data  (reg_rd_data),
        .base_o   (base_q),
        .mask_o   (mask_q),
        .valid_o  (valid_q)
    );

    pwin_space_match #(.BASE_W(BASE_W)) u_match (
        .addr_hi   (acc_addr[ADDR_W-1:WIN_BITS]),
        .acc_super (acc_super),
        .acc_code  (acc_code),
        .base      (base_q),
        .mask      (mask_q),
        .valid     (valid_q),
        .in_window (in_window),
        .win_hit   (win_hit)
    );

    always_comb begin
        req_vec             = '0;
        req_vec[TGT_MEM]    = mem_hit;
        req_vec[TGT_PERIPH] = win_hit;
        req_vec[TGT_CS]     = cs_hit;
        req_vec[TGT_EXT]    = 1'b1;
    end

    pwin_priority #(.NREQ(TGT_N)) u_prio (
        .req   (req_vec),
        .grant (tgt_sel)
    );

    // R12: one target only
    a_r12_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(tgt_sel));

    // R8: memory hit suppresses peripheral and external bus
    a_r8_mem_first: assert property (@(posedge clk) disable iff (!rst_n)
        mem_hit |-> (tgt_sel[TGT_MEM] && !tgt_sel[TGT_PERIPH] && !tgt_sel[TGT_EXT]));

    // R6: invalid register never selects the window
    a_r6_invalid_no_window: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd_data[VALID_B] |-> !tgt_sel[TGT_PERIPH]);

    // R7: masked in-window access with no other claim goes external
    a_r7_masked_goes_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (in_window && !win_hit && !mem_hit && !cs_hit) |-> tgt_sel[TGT_EXT]);

    // R9: window outranks chip-select
    a_r9_window_over_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (win_hit && cs_hit && !mem_hit) |-> tgt_sel[TGT_PERIPH]);

endmodule

// File: tb/pwin_decoder_bench.sv
`timescale 1ns/1ps
module pwin_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_super = 1'b0;
    logic        acc_code = 1'b0;
    logic        mem_hit = 1'b0;
    logic        cs_hit = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic [31:0] reg_rd_data;
    logic [3:0]  tgt_sel;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    logic [31:0] m_reg = '0;

    always #4 clk = ~clk;

    pwin_decoder u_pwin_decoder (
        .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_super(acc_super),
        .acc_code(acc_code), .mem_hit(mem_hit), .cs_hit(cs_hit),
        .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_data(reg_rd_data), .tgt_sel(tgt_sel)
    );

    // Reference model of the register
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_reg <= '0;
        else if (reg_wr_en && acc_super)
            m_reg <= {reg_wr_data[31:16], 11'd0, reg_wr_data[4:0]};
    end

    function automatic logic [3:0] exp_sel();
        int idx;
        bit hit;
        idx = (acc_super ? 2 : 0) + (acc_code ? 1 : 0);
        hit = m_reg[0] && (acc_addr[31:16] == m_reg[31:16]) && !m_reg[1 + idx];
        if (mem_hit) return 4'b0001;
        if (hit)     return 4'b0010;
        if (cs_hit)  return 4'b0100;
        return 4'b1000;
    endfunction

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            total++;
            if (tgt_sel !== exp_sel()) begin
                bad++;
                $display("FAIL %s tgt_sel actual=%b expected=%b", cur_req, tgt_sel, exp_sel());
            end
            total++;
            if (reg_rd_data !== m_reg) begin
                bad++;
                $display("FAIL %s rd_data actual=%h expected=%h", cur_req, reg_rd_data, m_reg);
            end
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(string req, logic [31:0] a, bit sup, bit code,
                        bit mh, bit ch, bit we, logic [31:0] wd);
        @(posedge clk); #1;
        cur_req = req;
        acc_addr = a; acc_super = sup; acc_code = code;
        mem_hit = mh; cs_hit = ch; reg_wr_en = we; reg_wr_data = wd;
        @(negedge clk); #1;
    endtask

    task automatic wr(string req, bit sup, logic [31:0] wd);
        step(req, 32'h0, sup, 1'b0, 1'b0, 1'b0, 1'b1, wd);
        step(req, 32'h0, sup, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        check("R1", reg_rd_data, 32'h0);
        step("R1", 32'h0000_0010, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
        check("R1", {28'h0, tgt_sel}, 32'h8);

        // R13 / R2
        wr("R13", 1'b1, 32'h1000_0001);
        check("R13", reg_rd_data, 32'h1000_0001);
        for (int t = 0; t < 4; t++) begin
            step("R5", 32'h1000_ABCD, t[1], t[0], 1'b0, 1'b0, 1'b0, 32'h0);
            check("R5", {28'h0, tgt_sel}, 32'h2);
        end
        step("R11", 32'h1001_0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
        check("R11", {28'h0, tgt_sel}, 32'h8);
        step("R11", 32'h0FFF_FFFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
        check("R11", {28'h0, tgt_sel}, 32'h8);

        // R3 reserved bits
        wr("R3", 1'b1, 32'hFFFF_FFFF);
        check("R3", reg_rd_data, 32'hFFFF_001F);
        wr("R2", 1'b1, 32'hABCD_8015);
        check("R2", reg_rd_data, 32'hABCD_0015);

        // R4 user write ignored
        wr("R4", 1'b0, 32'h2000_0001);
        check("R4", reg_rd_data, 32'hABCD_0015);

        // R7 each mask bit against each type
        for (int b = 0; b < 4; b++) begin
            wr("R7", 1'b1, 32'h1234_0001 | (32'h2 << b));
            for (int t = 0; t < 4; t++) begin
                step("R7", 32'h1234_0100, t[1], t[0], 1'b0, 1'b0, 1'b0, 32'h0);
                check("R7", {28'h0, tgt_sel}, (t == b) ? 32'h8 : 32'h2);
            end
        end

        // R6 valid clear
        wr("R6", 1'b1, 32'h1234_0000);
        for (int t = 0; t < 4; t++) begin
            step("R6", 32'h1234_0000, t[1], t[0], 1'b0, 1'b0, 1'b0, 32'h0);
            check("R6", {28'h0, tgt_sel}, 32'h8);
        end

        // Priority: all memory/window/chip-select combinations
        wr("R9", 1'b1, 32'h4000_0001);
        for (int c = 0; c < 8; c++) begin
            step((c[0]) ? "R8" : (c[1] ? "R9" : (c[2] ? "R10" : "R11")),
                 c[1] ? 32'h4000_2000 : 32'h5000_2000, 1'b0, 1'b1,
                 c[0], c[2], 1'b0, 32'h0);
            check(c[0] ? "R8" : (c[1] ? "R9" : (c[2] ? "R10" : "R11")),
                  {28'h0, tgt_sel},
                  c[0] ? 32'h1 : (c[1] ? 32'h2 : (c[2] ? 32'h4 : 32'h8)));
            check("R12", {31'h0, $onehot(tgt_sel)}, 32'h1);
        end

        // R2 relocation takes effect after the edge
        step("R2", 32'h4000_0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 32'h7700_0001);
        check("R2", {28'h0, tgt_sel}, 32'h2);
        step("R2", 32'h4000_0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
        check("R2", {28'h0, tgt_sel}, 32'h8);
        step("R2", 32'h7700_FFFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
        check("R2", {28'h0, tgt_sel}, 32'h2);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule